// File: doc/BRIEF.md
# Round-Robin Workgroup Dispatcher for a 3D Grid

This block walks a three-dimensional grid of workgroups and hands them, one at a time, to a set of compute units. A start pulse captures the grid extent and the workgroup size in each dimension. It clears the workgroup coordinates and the flat counter, and arms the block with work to hand out. Each compute unit reports through its own ready bit whether it can take a workgroup now.

A pass request makes the block probe every unit exactly once, one unit per cycle. The probing begins at a rotating pointer that survives from pass to pass. A probed unit gets a workgroup when it is ready and work is left. The issue carries the unit index, the X/Y/Z workgroup coordinates and a flat global ID. The pointer moves on after every probe, whether or not that unit got work. The coordinates advance X first, then carry into Y, then into Z. A dimension carries when its next index times the workgroup size reaches the grid extent. When Z carries, the grid is exhausted and the pass ends at once. At the end of the pass, a pulse reports completion and a flag reports whether anything was issued.

Top module: `wgd_dispatch`

## Requirements
- R1: After reset the block is idle (`busy_o`=0), holds no work (`remaining_o`=0), issues nothing, and `issue_cu_o`, `sched_any_o` and `pass_done_o` are 0.
- R2: A `start_i` pulse while idle captures the six size inputs. In the next cycle `remaining_o`=1 and the coordinates and `global_id_o` are 0. The rotating pointer is kept. While a pass is running, `start_i` is ignored.
- R3: An accepted `pass_i` starts a pass one cycle later. The pass probes at most `NUM_CU` units, one per cycle, and `issue_cu_o` shows the probed unit. `pass_done_o` pulses for one cycle in the cycle after the last probe, and `busy_o` is 1 exactly during the probe cycles.
- R4: The probed unit index goes up by one modulo `NUM_CU` after every probe, granted or not. The next pass begins at the unit after the last one probed.
- R5: `issue_valid_o` is 1 in a probe cycle only when `remaining_o`=1 and the ready bit of the probed unit is 1.
- R6: Every issue presents the current coordinates and global ID. Afterwards the X index goes up by one and `global_id_o` goes up by one.
- R7: When (X+1)·wg_x ≥ grid_x, X returns to 0 and Y goes up by one. The same rule carries Y into Z, using wg_y/grid_y.
- R8: When Z carries under the same rule with wg_z/grid_z, `remaining_o` drops to 0 and that probe is the last of the pass.
- R9: `sched_any_o` is cleared when a pass is accepted, and becomes 1 if the pass issued at least one workgroup. From `pass_done_o` on, it holds that value until the next pass.
- R10: `pass_i` is ignored while a pass is running; no second pass follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load sizes and rearm the grid walk |
| grid_x_i | input | SZ_W | Grid extent in X |
| grid_y_i | input | SZ_W | Grid extent in Y |
| grid_z_i | input | SZ_W | Grid extent in Z |
| wg_x_i | input | SZ_W | Workgroup size in X |
| wg_y_i | input | SZ_W | Workgroup size in Y |
| wg_z_i | input | SZ_W | Workgroup size in Z |
| pass_i | input | 1 | Request a dispatch pass |
| cu_ready_i | input | NUM_CU | Per-unit room for one workgroup |
| busy_o | output | 1 | Pass in progress (probe cycle) |
| remaining_o | output | 1 | Undispatched workgroups exist |
| issue_valid_o | output | 1 | Workgroup issued this cycle |
| issue_cu_o | output | PTR_W | Unit probed this cycle |
| wg_id_x_o | output | SZ_W | X coordinate of current workgroup |
| wg_id_y_o | output | SZ_W | Y coordinate of current workgroup |
| wg_id_z_o | output | SZ_W | Z coordinate of current workgroup |
| global_id_o | output | GID_W | Flat ID of current workgroup |
| pass_done_o | output | 1 | One-cycle end-of-pass pulse |
| sched_any_o | output | 1 | Last pass issued something |

## Verification
The bench uses grid extents that workgroup sizes do not divide. A design that carried on equality of the raw product, or on the index itself, would then skip a row or emit an extra partial tile. Passes with sparse ready masks show whether the pointer moves on unprobed-but-busy units; a design that moved it only on grants would start the next pass at the wrong unit. The grid is also made to run out in the middle of a pass. This catches a design that keeps probing after exhaustion, or that leaves the pointer anywhere but just past the last grant. Pass and start pulses are injected mid-pass, and an extra pass is requested on an exhausted grid. These expose a design that restarts, reloads, or reports work it did not issue.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  localparam int unsigned NUM_DIMS = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } pass_state_e;
endpackage

// File: rtl/wgd_dim_step.sv
module wgd_dim_step #(
  parameter int unsigned SZ_W = 8
) (
  input  logic [SZ_W-1:0] idx_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic [SZ_W-1:0] extent_i,
  input  logic            carry_i,
  output logic [SZ_W-1:0] idx_o,
  output logic            carry_o
);
  localparam int unsigned PROD_W = 2 * SZ_W;

  logic [SZ_W-1:0]   inc;
  logic [PROD_W-1:0] span;
  logic              wrap;

  always_comb begin
    inc  = idx_i + SZ_W'(1);
    // wide product, so a near-max index cannot alias below the extent
    span = PROD_W'(inc) * PROD_W'(size_i);
    wrap = carry_i && (span >= PROD_W'(extent_i));
    if (!carry_i) idx_o = idx_i;
    else if (wrap) idx_o = '0;
    else idx_o = inc;
    carry_o = wrap;
  end
endmodule

// File: rtl/wgd_id_walk.sv
module wgd_id_walk
  import wgd_pkg::*;
#(
  parameter int unsigned SZ_W  = 8,
  parameter int unsigned GID_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [NUM_DIMS-1:0][SZ_W-1:0] grid_i,
  input  logic [NUM_DIMS-1:0][SZ_W-1:0] wg_i,
  input  logic                          issue_i,
  output logic [NUM_DIMS-1:0][SZ_W-1:0] idx_o,
  output logic [GID_W-1:0]              gid_o,
  output logic                          remaining_o,
  output logic                          last_o
);
  logic [NUM_DIMS-1:0][SZ_W-1:0] grid_q, wg_q, idx_q, idx_d;
  logic [NUM_DIMS:0]             carry;
  logic [GID_W-1:0]              gid_q;
  logic                          rem_q;

  assign carry[0] = issue_i;

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    wgd_dim_step #(.SZ_W(SZ_W)) u_step (
      .idx_i   (idx_q[d]),
      .size_i  (wg_q[d]),
      .extent_i(grid_q[d]),
      .carry_i (carry[d]),
      .idx_o   (idx_d[d]),
      .carry_o (carry[d+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grid_q <= '0;
      wg_q   <= '0;
      idx_q  <= '0;
      gid_q  <= '0;
      rem_q  <= 1'b0;
    end else if (load_i) begin
      grid_q <= grid_i;
      wg_q   <= wg_i;
      idx_q  <= '0;
      gid_q  <= '0;
      rem_q  <= 1'b1;
    end else if (issue_i) begin
      idx_q <= idx_d;
      gid_q <= gid_q + GID_W'(1);
      if (carry[NUM_DIMS]) rem_q <= 1'b0;
    end
  end

  assign idx_o       = idx_q;
  assign gid_o       = gid_q;
  assign remaining_o = rem_q;
  assign last_o      = carry[NUM_DIMS];
endmodule

// File: rtl/wgd_rr_scan.sv
module wgd_rr_scan
  import wgd_pkg::*;
#(
  parameter int unsigned NUM_CU = 4,
  localparam int unsigned PTR_W = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_CU + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_req_i,
  input  logic              remaining_i,
  input  logic [NUM_CU-1:0] ready_i,
  input  logic              last_i,
  output logic [PTR_W-1:0]  probe_o,
  output logic              issue_o,
  output logic              busy_o,
  output logic              pass_done_o,
  output logic              sched_any_o
);
  pass_state_e      st_q;
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, sched_q, scanning, pass_end;

  assign scanning = (st_q == ST_SCAN);
  assign ptr_nxt  = (ptr_q == PTR_W'(NUM_CU - 1)) ? '0 : ptr_q + PTR_W'(1);
  assign issue_o  = scanning && remaining_i && ready_i[ptr_q];
  assign pass_end = (cnt_q == CNT_W'(NUM_CU - 1)) || last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      sched_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (pass_req_i) begin
            st_q    <= ST_SCAN;
            cnt_q   <= '0;
            sched_q <= 1'b0;
          end
        end
        default: begin
          ptr_q <= ptr_nxt;  // moves on every probe, grant or not
          if (issue_o) sched_q <= 1'b1;
          if (pass_end) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign probe_o     = ptr_q;
  assign busy_o      = scanning;
  assign pass_done_o = done_q;
  assign sched_any_o = sched_q;
endmodule

// File: rtl/wgd_dispatch.sv
module wgd_dispatch
  import wgd_pkg::*;
#(
  parameter int unsigned NUM_CU = 4,
  parameter int unsigned SZ_W   = 8,
  parameter int unsigned GID_W  = 16,
  localparam int unsigned PTR_W = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SZ_W-1:0]   grid_x_i,
  input  logic [SZ_W-1:0]   grid_y_i,
  input  logic [SZ_W-1:0]   grid_z_i,
  input  logic [SZ_W-1:0]   wg_x_i,
  input  logic [SZ_W-1:0]   wg_y_i,
  input  logic [SZ_W-1:0]   wg_z_i,
  input  logic              pass_i,
  input  logic [NUM_CU-1:0] cu_ready_i,
  output logic              busy_o,
  output logic              remaining_o,
  output logic              issue_valid_o,
  output logic [PTR_W-1:0]  issue_cu_o,
  output logic [SZ_W-1:0]   wg_id_x_o,
  output logic [SZ_W-1:0]   wg_id_y_o,
  output logic [SZ_W-1:0]   wg_id_z_o,
  output logic [GID_W-1:0]  global_id_o,
  output logic              pass_done_o,
  output logic              sched_any_o
);
  logic [NUM_DIMS-1:0][SZ_W-1:0] grid_v, wg_v, idx_v;
  logic load, pass_req, issue, rem, last, busy;

  assign grid_v   = {grid_z_i, grid_y_i, grid_x_i};
  assign wg_v     = {wg_z_i, wg_y_i, wg_x_i};
  assign load     = start_i && !busy;
  assign pass_req = pass_i && !busy;

  wgd_id_walk #(.SZ_W(SZ_W), .GID_W(GID_W)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .grid_i     (grid_v),
    .wg_i       (wg_v),
    .issue_i    (issue),
    .idx_o      (idx_v),
    .gid_o      (global_id_o),
    .remaining_o(rem),
    .last_o     (last)
  );

  wgd_rr_scan #(.NUM_CU(NUM_CU)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pass_req_i (pass_req),
    .remaining_i(rem),
    .ready_i    (cu_ready_i),
    .last_i     (last),
    .probe_o    (issue_cu_o),
    .issue_o    (issue),
    .busy_o     (busy),
    .pass_done_o(pass_done_o),
    .sched_any_o(sched_any_o)
  );

  assign busy_o        = busy;
  assign remaining_o   = rem;
  assign issue_valid_o = issue;
  assign wg_id_x_o     = idx_v[0];
  assign wg_id_y_o     = idx_v[1];
  assign wg_id_z_o     = idx_v[2];
endmodule

// File: rtl/wgd_dispatch_chk.sv
module wgd_dispatch_chk #(
  parameter int unsigned NUM_CU = 4,
  parameter int unsigned GID_W  = 16,
  localparam int unsigned PTR_W = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_CU + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             remaining_o,
  input logic             issue_valid_o,
  input logic [PTR_W-1:0] issue_cu_o,
  input logic [GID_W-1:0] global_id_o,
  input logic             pass_done_o,
  input logic             sched_any_o
);
  logic [CNT_W-1:0] run_len;
  logic [PTR_W-1:0] succ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
      succ    <= '0;
    end else begin
      run_len <= busy_o ? run_len + CNT_W'(1) : '0;
      succ    <= (issue_cu_o == PTR_W'(NUM_CU - 1)) ? '0 : issue_cu_o + PTR_W'(1);
    end
  end

  assert_pass_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_len < CNT_W'(NUM_CU)));

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (issue_cu_o == succ));

  assert_issue_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (busy_o && remaining_o));

  assert_gid_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> (global_id_o == $past(global_id_o) + GID_W'(1)));

  assert_drain_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(remaining_o) |-> (pass_done_o && !busy_o));

  assert_sched_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_done_o && $past(issue_valid_o)) |-> sched_any_o);
endmodule

bind wgd_dispatch wgd_dispatch_chk #(.NUM_CU(NUM_CU), .GID_W(GID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .remaining_o  (remaining_o),
  .issue_valid_o(issue_valid_o),
  .issue_cu_o   (issue_cu_o),
  .global_id_o  (global_id_o),
  .pass_done_o  (pass_done_o),
  .sched_any_o  (sched_any_o)
);

// File: tb/wgd_dispatch_bench.sv
`timescale 1ns/1ps
module wgd_dispatch_bench;
  localparam int N     = 4;
  localparam int SZ_W  = 8;
  localparam int GID_W = 16;
  localparam int PTR_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pass_req = 1'b0;
  logic [SZ_W-1:0] gx = '0, gy = '0, gz = '0, wx = '0, wy = '0, wz = '0;
  logic [N-1:0] ready = '0;
  logic busy, rem, iv, pdone, sched;
  logic [PTR_W-1:0] icu;
  logic [SZ_W-1:0] idx, idy, idz;
  logic [GID_W-1:0] gid;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  // bench model
  int m_ptr = 0, m_x = 0, m_y = 0, m_z = 0, m_gid = 0, cx = 1, cy = 1, cz = 1;
  bit m_rem = 1'b0;

  always #5 clk = ~clk;

  wgd_dispatch #(.NUM_CU(N), .SZ_W(SZ_W), .GID_W(GID_W)) u_wgd_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .grid_x_i(gx), .grid_y_i(gy), .grid_z_i(gz),
    .wg_x_i(wx), .wg_y_i(wy), .wg_z_i(wz),
    .pass_i(pass_req), .cu_ready_i(ready),
    .busy_o(busy), .remaining_o(rem), .issue_valid_o(iv), .issue_cu_o(icu),
    .wg_id_x_o(idx), .wg_id_y_o(idy), .wg_id_z_o(idz), .global_id_o(gid),
    .pass_done_o(pdone), .sched_any_o(sched)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1", "busy", int'(busy), 0);
    chk_eq("R1", "remaining", int'(rem), 0);
    chk_eq("R1", "issue_valid", int'(iv), 0);
    chk_eq("R1", "issue_cu", int'(icu), 0);
    chk_eq("R1", "sched_any", int'(sched), 0);
    chk_eq("R1", "pass_done", int'(pdone), 0);
    m_ptr = 0; m_rem = 1'b0;
  endtask

  task automatic do_start(input int a, input int b, input int c,
                          input int p, input int q, input int r);
    @(negedge clk);
    gx = SZ_W'(a); gy = SZ_W'(b); gz = SZ_W'(c);
    wx = SZ_W'(p); wy = SZ_W'(q); wz = SZ_W'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cx = (a + p - 1) / p; cy = (b + q - 1) / q; cz = (c + r - 1) / r;
    m_x = 0; m_y = 0; m_z = 0; m_gid = 0; m_rem = 1'b1;
    chk_eq("R2", "remaining after start", int'(rem), 1);
    chk_eq("R2", "ids cleared", int'(idx) + int'(idy) + int'(idz), 0);
    chk_eq("R2", "gid cleared", int'(gid), 0);
    chk_eq("R2", "pointer kept", int'(icu), m_ptr);
  endtask

  // model advance, written from per-dimension tile counts
  task automatic model_step();
    m_gid++;
    m_x++;
    if (m_x == cx) begin
      m_x = 0; m_y++;
      if (m_y == cy) begin
        m_y = 0; m_z++;
        if (m_z == cz) begin
          m_z = 0; m_rem = 1'b0;
        end
      end
    end
  endtask

  task automatic run_pass(input logic [N-1:0] mask, input bit disturb);
    int probes = 0, issued = 0;
    bit fin = 1'b0;
    bit exp_iss;
    @(negedge clk);
    ready = mask; pass_req = 1'b1;
    @(negedge clk);
    pass_req = 1'b0;
    while (!fin) begin
      exp_iss = m_rem && mask[m_ptr];
      chk_eq("R3", "busy in probe", int'(busy), 1);
      chk_eq("R4", "probed unit", int'(icu), m_ptr);
      chk_eq("R5", "issue_valid", int'(iv), int'(exp_iss));
      if (exp_iss) begin
        chk_eq("R6", "wg x", int'(idx), m_x);
        chk_eq("R7", "wg y", int'(idy), m_y);
        chk_eq("R7", "wg z", int'(idz), m_z);
        chk_eq("R6", "global id", int'(gid), m_gid);
        model_step();
        issued++;
        if (!m_rem) fin = 1'b1;
      end
      m_ptr = (m_ptr + 1) % N;
      probes++;
      if (probes == N) fin = 1'b1;
      if (disturb && probes == 1) begin
        pass_req = 1'b1; start = 1'b1;
        gx = 8'd1; gy = 8'd1; gz = 8'd1;
      end
      @(negedge clk);
      pass_req = 1'b0; start = 1'b0;
    end
    chk_eq("R3", "pass_done pulse", int'(pdone), 1);
    chk_eq("R3", "busy after pass", int'(busy), 0);
    chk_eq("R9", "sched_any", int'(sched), int'(issued > 0));
    chk_eq("R8", "remaining", int'(rem), int'(m_rem));
    @(negedge clk);
    chk_eq("R10", "no second pass", int'(busy), 0);
    chk_eq("R3", "pass_done one cycle", int'(pdone), 0);
    chk_eq("R9", "sched_any held", int'(sched), int'(issued > 0));
  endtask

  task automatic t_even_grid();
    do_start(8, 4, 2, 4, 2, 2);       // 2 x 2 x 1 workgroups
    run_pass(4'b1111, 1'b0);
    chk_eq("R8", "drained after 4", int'(rem), 0);
  endtask

  task automatic t_pointer();
    do_start(3, 1, 1, 1, 1, 1);       // three workgroups, pass stops early
    run_pass(4'b1111, 1'b0);
    chk_eq("R8", "pointer past last grant", int'(icu), 3);
    do_start(6, 1, 1, 1, 1, 1);
    run_pass(4'b1010, 1'b0);          // starts at unit 3
    run_pass(4'b0000, 1'b0);          // no grants, pointer still moves
    run_pass(4'b0100, 1'b0);
  endtask

  task automatic t_ragged();
    do_start(5, 3, 3, 2, 2, 2);       // 3 x 2 x 2 = 12 workgroups
    run_pass(4'b1111, 1'b1);          // start/pass pulses mid-pass ignored
    while (m_rem) run_pass(4'b1111, 1'b0);
    chk_eq("R8", "gid at drain", int'(gid), 12);
  endtask

  task automatic t_exhausted();
    run_pass(4'b1111, 1'b0);
    chk_eq("R5", "no issue when drained", int'(sched), 0);
  endtask

  initial begin
    t_reset();
    t_even_grid();
    t_pointer();
    t_ragged();
    t_exhausted();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule